// File: doc/BRIEF.md
# IR Pulse-Width Capture Receiver

This block times the marks and spaces of a demodulated infrared envelope and stores one word per measured pulse in a small receive FIFO. A glitch filter first removes short spikes from the envelope. A selectable edge mode decides which transitions end one pulse and start the next. The width counter runs from an externally divided tick, and it advances once for every four ticks.

Software drains the FIFO through a read strobe. The read word carries a valid flag, the pulse level and the count. Status outputs report an active measurement, a FIFO service request, a counter timeout and a FIFO overrun. The timeout, overrun and service-request statuses each have their own enable, and the enabled ones are combined into a single interrupt line. The count width (`CW`, default 16), the filter count width (`FW`, default 16) and the FIFO depth (`DEPTH`, default 8) are parameters.

Top module: `ir_pw_rx`

## Requirements
- R1: A read word is laid out as follows: count in bits [CW-1:0], pulse level in bit CW, and a valid flag in bit CW+1. With the tick high every clock, a pulse that lasts L clocks between two timing edges is stored with count floor((L-1)/4).
- R2: The edge select chooses which transitions time a pulse: 00 times nothing, 01 uses falling edges, 10 uses rising edges, and 11 uses both. The first qualifying edge only starts timing. Each later qualifying edge stores the running pulse and starts the next one.
- R3: `busy_o` is high from the edge that starts a measurement until timing stops. Timing stops when the counter overflows or when `rx_en_i` is low.
- R4: When the counter would pass its all-ones value, `timeout_o` is set, timing stops, and the all-ones marker (CW+1 ones, so 0x1FFFF by default) is stored. With `ovf_quiet_i` high, nothing is stored.
- R5: `timeout_o` stays set until `rx_en_i` is driven low, which clears it.
- R6: The FIFO holds DEPTH words. A store into a full FIFO drops the word, keeps the older words, and sets `overrun_o`.
- R7: Driving `fifo_en_i` low empties the FIFO and clears `overrun_o`.
- R8: When the FIFO is empty, the read word is all zeros, valid flag included. A read strobe on an empty FIFO changes nothing.
- R9: With `wm_any_i` low, `svc_req_o` is high when at least DEPTH/2 words are held. With `wm_any_i` high, it is high whenever at least one word is held.
- R10: The glitch filter passes a level change only after it has persisted for `flt_min_i` consecutive clocks, so shorter pulses are not seen. A value of 0 or 1 passes every change after a single clock.
- R11: `irq_o` is high when timeout, overrun or service request is active together with its own enable, and is low otherwise.
- R12: The count advances only on clocks where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env_i | input | 1 | Demodulated envelope, synchronous to clk |
| tick_i | input | 1 | Divided-clock tick, one clock wide |
| edge_sel_i | input | 2 | Timing edge select (R2 encoding) |
| flt_min_i | input | FW | Glitch filter minimum width in clocks |
| rx_en_i | input | 1 | Receiver enable |
| fifo_en_i | input | 1 | FIFO enable; low flushes |
| ovf_quiet_i | input | 1 | Suppress marker store on overflow |
| wm_any_i | input | 1 | Service watermark: 0 half full, 1 not empty |
| ie_timeout_i | input | 1 | Interrupt enable for timeout |
| ie_overrun_i | input | 1 | Interrupt enable for overrun |
| ie_service_i | input | 1 | Interrupt enable for service request |
| rd_en_i | input | 1 | Pop the FIFO head |
| rd_word_o | output | CW+2 | Valid flag, level and count of the FIFO head |
| busy_o | output | 1 | A pulse is being timed |
| svc_req_o | output | 1 | FIFO service request |
| timeout_o | output | 1 | Width counter overflowed |
| overrun_o | output | 1 | Store attempted into a full FIFO |
| irq_o | output | 1 | Masked interrupt |

## Verification
The hardest state to reach from the ports is counter overflow. At the default width it needs more than a quarter million ticks without an edge. The bench therefore builds the block with an 8-bit count, holds the envelope steady past 1024 ticks, and checks the marker in both the storing and the quiet setting. Overrun is the second hard case, because it only happens when more pulses arrive than the FIFO holds with no read in between. The bench drives nine short pulses back to back with no reads, then checks that the oldest word is still at the head.

// File: rtl/ir_pw_pkg.sv
package ir_pw_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // divided-clock ticks per increment of the width counter
  localparam int unsigned TICKS_PER_COUNT = 4;

endpackage

// File: rtl/ir_pw_glitch.sv
module ir_pw_glitch #(
  parameter int unsigned FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raw_i,
  input  logic [FW-1:0] min_i,
  output logic          filt_o
);

  logic [FW-1:0] run_q, run_d;
  logic          filt_q, filt_d;
  logic [FW:0]   run_inc;

  assign run_inc = {1'b0, run_q} + 1'b1;

  always_comb begin
    run_d  = '0;
    filt_d = filt_q;
    if (raw_i != filt_q) begin
      if (run_inc >= {1'b0, min_i}) begin
        filt_d = raw_i;
      end else begin
        run_d = run_inc[FW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

  // R10: with the filter off, the output follows the input one clock later
  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (min_i == '0) |=> (filt_o == $past(raw_i)));

endmodule

// File: rtl/ir_pw_timer.sv
module ir_pw_timer
  import ir_pw_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  input  logic          tick_i,
  input  edge_mode_e    mode_i,
  input  logic          run_en_i,
  input  logic          ovf_quiet_i,
  output logic          push_o,
  output logic [CW:0]   push_word_o,
  output logic          busy_o,
  output logic          timeout_o
);

  localparam int unsigned PW = (TICKS_PER_COUNT > 1) ? $clog2(TICKS_PER_COUNT) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_COUNT - 1);

  logic          prev_q, busy_q, busy_d, lvl_q, lvl_d, to_q, to_d;
  logic [PW-1:0] pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise, fall, hit_raw, hit, carry;

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      EDGE_FALL: hit_raw = fall;
      EDGE_RISE: hit_raw = rise;
      EDGE_BOTH: hit_raw = rise | fall;
      default:   hit_raw = 1'b0;
    endcase
  end

  assign hit   = hit_raw & run_en_i;
  assign carry = busy_q & tick_i & (pre_q == PRE_LAST);

  always_comb begin
    busy_d      = busy_q;
    lvl_d       = lvl_q;
    to_d        = to_q;
    pre_d       = pre_q;
    cnt_d       = cnt_q;
    push_o      = 1'b0;
    push_word_o = {lvl_q, cnt_q};
    if (!run_en_i) begin
      busy_d = 1'b0;
      to_d   = 1'b0;
      pre_d  = '0;
      cnt_d  = '0;
    end else if (hit) begin
      push_o = busy_q;
      busy_d = 1'b1;
      lvl_d  = lvl_i;
      pre_d  = '0;
      cnt_d  = '0;
    end else if (busy_q && tick_i) begin
      pre_d = carry ? '0 : pre_q + 1'b1;
      if (carry) begin
        if (cnt_q == '1) begin
          busy_d      = 1'b0;
          to_d        = 1'b1;
          push_o      = ~ovf_quiet_i;
          push_word_o = '1;
          cnt_d       = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      to_q   <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      busy_q <= busy_d;
      lvl_q  <= lvl_d;
      to_q   <= to_d;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o    = busy_q;
  assign timeout_o = to_q;

  // R4: a timeout can only follow an active measurement
  a_r4_timeout_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> $past(busy_q));
  // R3, R5: a disabled receiver is idle and its timeout is clear
  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en_i |=> (!busy_q && !to_q));
  // R12: without a tick the count does not move while timing continues
  a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i && !hit && run_en_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/ir_pw_fifo.sv
module ir_pw_fifo #(
  parameter int unsigned WW    = 17,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          push_i,
  input  logic [WW-1:0] data_i,
  input  logic          pop_i,
  input  logic          wm_any_i,
  output logic [WW-1:0] head_o,
  output logic          nonempty_o,
  output logic          svc_o,
  output logic          ovr_o
);

  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW   = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          ovr_q, ovr_d;
  logic          full, empty, do_push, do_pop;

  assign full    = (lvl_q == FULL);
  assign empty   = (lvl_q == '0);
  assign do_push = en_i & push_i & ~full;
  assign do_pop  = en_i & pop_i & ~empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    ovr_d = ovr_q;
    if (!en_i) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
      ovr_d = 1'b0;
    end else begin
      if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop) lvl_d = lvl_q + 1'b1;
      if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
      if (push_i && full) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      ovr_q <= ovr_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_q == AW'(g))) mem[g] <= data_i;
    end
  end

  assign head_o     = mem[rd_q];
  assign nonempty_o = ~empty;
  assign svc_o      = wm_any_i ? ~empty : (lvl_q >= HALF);
  assign ovr_o      = ovr_q;

  // R6: a store into a full FIFO flags overrun and keeps the level
  a_r6_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && push_i && full && !pop_i) |=> (ovr_q && lvl_q == FULL));
  // R6: the level never exceeds the depth
  a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= FULL);
  // R7: disabling the FIFO empties it and clears overrun
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (lvl_q == '0 && !ovr_q));

endmodule

// File: rtl/ir_pw_rx.sv
module ir_pw_rx
  import ir_pw_pkg::*;
#(
  parameter int unsigned CW    = 16,
  parameter int unsigned FW    = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          env_i,
  input  logic          tick_i,
  input  logic [1:0]    edge_sel_i,
  input  logic [FW-1:0] flt_min_i,
  input  logic          rx_en_i,
  input  logic          fifo_en_i,
  input  logic          ovf_quiet_i,
  input  logic          wm_any_i,
  input  logic          ie_timeout_i,
  input  logic          ie_overrun_i,
  input  logic          ie_service_i,
  input  logic          rd_en_i,
  output logic [CW+1:0] rd_word_o,
  output logic          busy_o,
  output logic          svc_req_o,
  output logic          timeout_o,
  output logic          overrun_o,
  output logic          irq_o
);

  localparam int unsigned WW = CW + 1;

  logic          filt;
  edge_mode_e    mode;
  logic          push;
  logic [WW-1:0] push_word, head;
  logic          nonempty;

  assign mode = edge_mode_e'(edge_sel_i);

  ir_pw_glitch #(.FW(FW)) u_glitch (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (env_i),
    .min_i  (flt_min_i),
    .filt_o (filt)
  );

  ir_pw_timer #(.CW(CW)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_i       (filt),
    .tick_i      (tick_i),
    .mode_i      (mode),
    .run_en_i    (rx_en_i),
    .ovf_quiet_i (ovf_quiet_i),
    .push_o      (push),
    .push_word_o (push_word),
    .busy_o      (busy_o),
    .timeout_o   (timeout_o)
  );

  ir_pw_fifo #(.WW(WW), .DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (fifo_en_i),
    .push_i     (push),
    .data_i     (push_word),
    .pop_i      (rd_en_i),
    .wm_any_i   (wm_any_i),
    .head_o     (head),
    .nonempty_o (nonempty),
    .svc_o      (svc_req_o),
    .ovr_o      (overrun_o)
  );

  assign rd_word_o = {nonempty, nonempty ? head : {WW{1'b0}}};
  assign irq_o     = (timeout_o & ie_timeout_i) | (overrun_o & ie_overrun_i) |
                     (svc_req_o & ie_service_i);

  // R9: no service request while the read port shows no valid word
  a_r9_no_service_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word_o[CW+1] |-> !svc_req_o);
  // R11: an interrupt needs at least one enable
  a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ie_timeout_i || ie_overrun_i || ie_service_i));
  // R8: an empty read port carries an all-zero word
  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_word_o[CW+1] |-> (rd_word_o == '0));

endmodule

// File: tb/ir_pw_rx_test.sv
`timescale 1ns/1ps
module ir_pw_rx_test;

  localparam int CW = 8;
  localparam int FW = 16;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          env_i = 1'b0;
  logic          tick_i = 1'b1;
  logic [1:0]    edge_sel_i = 2'b11;
  logic [FW-1:0] flt_min_i = '0;
  logic          rx_en_i = 1'b0;
  logic          fifo_en_i = 1'b0;
  logic          ovf_quiet_i = 1'b0;
  logic          wm_any_i = 1'b0;
  logic          ie_timeout_i = 1'b0;
  logic          ie_overrun_i = 1'b0;
  logic          ie_service_i = 1'b0;
  logic          rd_en_i = 1'b0;
  logic [CW+1:0] rd_word_o;
  logic          busy_o, svc_req_o, timeout_o, overrun_o, irq_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ir_pw_rx #(.CW(CW), .FW(FW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .env_i(env_i), .tick_i(tick_i),
    .edge_sel_i(edge_sel_i), .flt_min_i(flt_min_i), .rx_en_i(rx_en_i),
    .fifo_en_i(fifo_en_i), .ovf_quiet_i(ovf_quiet_i), .wm_any_i(wm_any_i),
    .ie_timeout_i(ie_timeout_i), .ie_overrun_i(ie_overrun_i),
    .ie_service_i(ie_service_i), .rd_en_i(rd_en_i), .rd_word_o(rd_word_o),
    .busy_o(busy_o), .svc_req_o(svc_req_o), .timeout_o(timeout_o),
    .overrun_o(overrun_o), .irq_o(irq_o)
  );

  function automatic logic [CW+1:0] exp_word(input logic lvl, input int len);
    return {1'b1, lvl, CW'((len - 1) / 4)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic lvl, input int len);
    env_i = lvl;
    step(len);
  endtask

  task automatic read_word(output logic [CW+1:0] w);
    w = rd_word_o;
    rd_en_i = 1'b1;
    step(1);
    rd_en_i = 1'b0;
  endtask

  task automatic setup(input logic [1:0] sel, input int flt);
    rx_en_i = 1'b0;
    fifo_en_i = 1'b0;
    env_i = 1'b0;
    step(20);
    edge_sel_i = sel;
    flt_min_i = FW'(flt);
    rx_en_i = 1'b1;
    fifo_en_i = 1'b1;
    step(2);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [CW+1:0] w;
    int lens[4];
    void'($urandom(32'd2024));
    step(3);
    rst_n = 1'b1;
    step(2);

    // reset state
    chk("R8 reset word", 32'(rd_word_o), 32'h0);
    chk("R3 reset busy", 32'(busy_o), 32'h0);
    chk("R9 reset svc", 32'(svc_req_o), 32'h0);
    chk("R4 reset timeout", 32'(timeout_o), 32'h0);
    chk("R6 reset overrun", 32'(overrun_o), 32'h0);
    chk("R11 reset irq", 32'(irq_o), 32'h0);

    // R1 R2: both edges, directed
    setup(2'b11, 0);
    pulse(1'b1, 17); pulse(1'b0, 9); pulse(1'b1, 40); pulse(1'b0, 5);
    env_i = 1'b1;
    step(3);
    chk("R3 busy while timing", 32'(busy_o), 32'h1);
    read_word(w); chk("R1 word 0", 32'(w), 32'(exp_word(1'b1, 17)));
    read_word(w); chk("R1 word 1", 32'(w), 32'(exp_word(1'b0, 9)));
    read_word(w); chk("R2 word 2", 32'(w), 32'(exp_word(1'b1, 40)));
    read_word(w); chk("R2 word 3", 32'(w), 32'(exp_word(1'b0, 5)));
    chk("R8 empty after drain", 32'(rd_word_o), 32'h0);
    read_word(w); chk("R8 pop on empty", 32'(rd_word_o), 32'h0);
    rx_en_i = 1'b0;
    step(2);
    chk("R3 busy drops when disabled", 32'(busy_o), 32'h0);

    // random batches
    for (int b = 0; b < 6; b++) begin
      setup(2'b11, 0);
      for (int i = 0; i < 4; i++) begin
        lens[i] = 5 + int'($urandom % 296);
        pulse((i % 2) == 0, lens[i]);
      end
      env_i = 1'b1;
      step(3);
      chk("R9 half full svc", 32'(svc_req_o), 32'h1);
      for (int i = 0; i < 4; i++) begin
        read_word(w);
        chk("R1 random word", 32'(w), 32'(exp_word((i % 2) == 0, lens[i])));
      end
      chk("R8 random drained", 32'(rd_word_o), 32'h0);
    end

    // R9 watermark, R11 gating
    setup(2'b11, 0);
    pulse(1'b1, 10); pulse(1'b0, 10); pulse(1'b1, 10);
    env_i = 1'b0;
    step(3);
    chk("R9 three words below half", 32'(svc_req_o), 32'h0);
    wm_any_i = 1'b1;
    step(1);
    chk("R9 not-empty watermark", 32'(svc_req_o), 32'h1);
    chk("R11 svc masked", 32'(irq_o), 32'h0);
    ie_service_i = 1'b1;
    step(1);
    chk("R11 svc enabled", 32'(irq_o), 32'h1);
    ie_service_i = 1'b0;
    for (int i = 0; i < 3; i++) read_word(w);
    chk("R9 empty no svc", 32'(svc_req_o), 32'h0);
    wm_any_i = 1'b0;

    // R6 overrun, R7 flush
    setup(2'b11, 0);
    for (int i = 0; i < 9; i++) pulse((i % 2) == 0, 8 + 4 * i);
    env_i = 1'b0;
    step(3);
    chk("R6 overrun set", 32'(overrun_o), 32'h1);
    chk("R11 overrun masked", 32'(irq_o), 32'h0);
    ie_overrun_i = 1'b1;
    step(1);
    chk("R11 overrun irq", 32'(irq_o), 32'h1);
    ie_overrun_i = 1'b0;
    chk("R6 oldest kept", 32'(rd_word_o), 32'(exp_word(1'b1, 8)));
    fifo_en_i = 1'b0;
    step(2);
    chk("R7 overrun cleared", 32'(overrun_o), 32'h0);
    chk("R7 flushed", 32'(rd_word_o), 32'h0);

    // R4 timeout with marker, R5 clear
    setup(2'b11, 0);
    env_i = 1'b1;
    step(1100);
    chk("R4 timeout set", 32'(timeout_o), 32'h1);
    chk("R3 busy off after overflow", 32'(busy_o), 32'h0);
    chk("R4 marker word", 32'(rd_word_o), 32'h3FF);
    ie_timeout_i = 1'b1;
    step(1);
    chk("R11 timeout irq", 32'(irq_o), 32'h1);
    ie_timeout_i = 1'b0;
    step(5);
    chk("R5 timeout sticky", 32'(timeout_o), 32'h1);
    rx_en_i = 1'b0;
    step(2);
    chk("R5 timeout cleared", 32'(timeout_o), 32'h0);

    // R4 quiet overflow
    ovf_quiet_i = 1'b1;
    setup(2'b11, 0);
    env_i = 1'b1;
    step(1100);
    chk("R4 quiet timeout", 32'(timeout_o), 32'h1);
    chk("R4 quiet no word", 32'(rd_word_o), 32'h0);
    ovf_quiet_i = 1'b0;

    // R12 no ticks
    tick_i = 1'b0;
    setup(2'b11, 0);
    pulse(1'b1, 40);
    env_i = 1'b0;
    step(3);
    chk("R12 count frozen", 32'(rd_word_o), 32'h300);
    tick_i = 1'b1;

    // R2 falling edges
    setup(2'b01, 0);
    pulse(1'b1, 20);
    chk("R2 rise ignored in fall mode", 32'(busy_o), 32'h0);
    pulse(1'b0, 30); pulse(1'b1, 50);
    env_i = 1'b0;
    step(3);
    read_word(w);
    chk("R2 falling period", 32'(w), 32'(exp_word(1'b0, 80)));
    chk("R2 one word only", 32'(rd_word_o), 32'h0);

    // R2 rising edges
    setup(2'b10, 0);
    pulse(1'b1, 30); pulse(1'b0, 26);
    env_i = 1'b1;
    step(3);
    read_word(w);
    chk("R2 rising period", 32'(w), 32'(exp_word(1'b1, 56)));

    // R2 timing off
    setup(2'b00, 0);
    pulse(1'b1, 12); pulse(1'b0, 12); pulse(1'b1, 12);
    chk("R2 off not busy", 32'(busy_o), 32'h0);
    chk("R2 off no word", 32'(rd_word_o), 32'h0);

    // R10 glitch filter
    setup(2'b11, 10);
    pulse(1'b1, 50); pulse(1'b0, 6); pulse(1'b1, 44); pulse(1'b0, 60);
    env_i = 1'b1;
    step(14);
    read_word(w);
    chk("R10 glitch merged", 32'(w), 32'(exp_word(1'b1, 100)));
    read_word(w);
    chk("R10 space after", 32'(w), 32'(exp_word(1'b0, 60)));
    chk("R10 no extra word", 32'(rd_word_o), 32'h0);

    finish_run();
  end

endmodule